// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block sits between the datapath of an 8-bit controller and its 4096-byte data memory. It holds three 12-bit pointers. Each pointer is stored as a low byte and a high byte of which four bits are used. Every pointer owns a small window of virtual addresses. An access to a virtual address is never sent to storage as it stands. The block resolves it to an effective address that it forms from the pointer. The slot within the window picks the mode: plain, post-decrement, post-increment, pre-increment, or indexed by the signed working-register value. Any change to the pointer is committed at the clock edge that ends the access.

The memory port and the outputs are combinational from the request and from the current pointer state, so the block handles one access per cycle. The block holds the pointer byte registers itself and serves them at their own addresses. It stops an access that would loop back onto a virtual address: a read returns zero and raises a zero hint, and a write does nothing. All other addresses pass straight through to memory.

Top module: `indptr_unit`

## Requirements
- R1: An active-high synchronous reset sets all three pointers to 0x000. After reset every pointer byte reads back as 00h.
- R2: Pointer n has its low byte at address 0xFD8+2n and its high byte at 0xFD9+2n. A write to either address loads that byte, and a read returns it. Only bits 3:0 of the high byte are kept, and bits 7:4 read as zero. These accesses assert neither memory strobe.
- R3: The virtual window of pointer n starts at 0xFE0+8n. Slot 0 (plain) accesses memory at the pointer and leaves the pointer unchanged.
- R4: Slot 1 (post-decrement) accesses memory at the pointer, and the pointer then becomes pointer-1.
- R5: Slot 2 (post-increment) accesses memory at the pointer, and the pointer then becomes pointer+1.
- R6: Slot 3 (pre-increment) accesses memory at pointer+1, and that value becomes the new pointer.
- R7: Slot 4 (indexed) accesses memory at the pointer plus the sign-extended working-register value (-128 to +127). The pointer is not changed.
- R8: All pointer arithmetic and the indexed sum act on the full 12 bits modulo 4096. A carry or borrow crosses from the low byte into the high byte, and 0xFFF+1 gives 0x000.
- R9: If the effective address falls on any virtual slot (0xFE0+8n+m, m from 0 to 4), a read returns 00h with zero_hint high and no memory strobe. The mode's change to the addressing pointer is still applied.
- R10: If the effective address of a write falls on a virtual slot, no memory strobe occurs and no pointer changes.
- R11: An indirect write whose effective address is a pointer byte loads that byte and applies no change from the mode to the addressing pointer. An indirect read of a pointer byte returns the byte and does apply the mode's change. Neither drives a memory strobe.
- R12: Every other address, including slots 5 to 7 of a window, passes through. mem_addr equals req_addr, the strobes follow rd_en and wr_en, rd_data equals mem_rdata, and zero_hint stays low. mem_wdata always carries wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | 12 | Address requested by the datapath |
| rd_en | input | 1 | Read strobe for this cycle |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 8 | Data to write |
| wreg | input | 8 | Working-register value, used as a signed offset in indexed mode |
| mem_addr | output | 12 | Resolved address sent to data memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data for mem_addr |
| rd_data | output | 8 | Read result returned to the datapath |
| zero_hint | output | 1 | High on a read that loops back to a virtual slot |

## Verification
The assertions take as given that rd_en and wr_en are never high in the same cycle. One of them checks this input rule directly. The pointer-step and hold properties likewise assume that mem_rdata is a pure function of mem_addr within the cycle. The stimulus issues at most one strobe per cycle. It drives every input on the falling edge. Its memory model is a fixed function of the address. Each pointer is set up by direct byte writes before an indirect access, so every effective address is known ahead of time.

// File: rtl/indptr_pkg.sv
package indptr_pkg;

   typedef enum logic [2:0] {
      MODE_PLAIN   = 3'd0,
      MODE_POSTDEC = 3'd1,
      MODE_POSTINC = 3'd2,
      MODE_PREINC  = 3'd3,
      MODE_INDEX   = 3'd4
   } ptr_mode_e;

   localparam int unsigned NUM_MODES = 5;

endpackage

// File: rtl/indptr_addr_class.sv
module indptr_addr_class
   import indptr_pkg::*;
#(
   parameter int unsigned     ADDR_W    = 12,
   parameter int unsigned     NUM_PTR   = 3,
   parameter int unsigned     STRIDE_LG = 3,
   parameter logic [ADDR_W-1:0] VIRT_BASE = 'hFE0,
   parameter logic [ADDR_W-1:0] PREG_BASE = 'hFD8,
   localparam int unsigned    IDX_W     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_virt,
   output logic [IDX_W-1:0]  virt_idx,
   output ptr_mode_e         virt_mode,
   output logic              is_preg,
   output logic [IDX_W-1:0]  preg_idx,
   output logic              preg_hi
);

   localparam logic [ADDR_W:0]      VWIN_LEN   = (ADDR_W+1)'(NUM_PTR << STRIDE_LG);
   localparam logic [ADDR_W:0]      PWIN_LEN   = (ADDR_W+1)'(2 * NUM_PTR);
   localparam logic [STRIDE_LG-1:0] MODE_LIMIT = STRIDE_LG'(NUM_MODES);

   logic [ADDR_W-1:0]    voff;
   logic [ADDR_W-1:0]    poff;
   logic [STRIDE_LG-1:0] slot;
   logic                 in_vwin;

   always_comb begin
      voff      = addr - VIRT_BASE;
      poff      = addr - PREG_BASE;
      slot      = voff[STRIDE_LG-1:0];
      in_vwin   = (addr >= VIRT_BASE) && ({1'b0, voff} < VWIN_LEN);
      is_virt   = in_vwin && (slot < MODE_LIMIT);
      virt_idx  = voff[STRIDE_LG +: IDX_W];
      virt_mode = ptr_mode_e'(slot[2:0]);
      is_preg   = (addr >= PREG_BASE) && ({1'b0, poff} < PWIN_LEN);
      preg_idx  = poff[1 +: IDX_W];
      preg_hi   = poff[0];
   end

endmodule

// File: rtl/indptr_ea_calc.sv
module indptr_ea_calc
   import indptr_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 8
) (
   input  logic [ADDR_W-1:0] ptr_cur,
   input  ptr_mode_e         mode,
   input  logic [DATA_W-1:0] offs,
   output logic [ADDR_W-1:0] ea,
   output logic [ADDR_W-1:0] ptr_next,
   output logic              modifies
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   logic [ADDR_W-1:0] inc_v;
   logic [ADDR_W-1:0] dec_v;
   logic [ADDR_W-1:0] idx_v;

   always_comb begin
      inc_v = ptr_cur + ONE;
      dec_v = ptr_cur - ONE;
      idx_v = ptr_cur + {{(ADDR_W-DATA_W){offs[DATA_W-1]}}, offs};
      ea       = ptr_cur;
      ptr_next = ptr_cur;
      modifies = 1'b0;
      unique case (mode)
         MODE_POSTDEC: begin ptr_next = dec_v; modifies = 1'b1; end
         MODE_POSTINC: begin ptr_next = inc_v; modifies = 1'b1; end
         MODE_PREINC:  begin ea = inc_v; ptr_next = inc_v; modifies = 1'b1; end
         MODE_INDEX:   ea = idx_v;
         default:      ;
      endcase
   end

endmodule

// File: rtl/indptr_regs.sv
module indptr_regs #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned NUM_PTR = 3,
   localparam int unsigned IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1,
   localparam int unsigned HI_W   = ADDR_W - DATA_W
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             byte_we,
   input  logic [IDX_W-1:0]                 byte_idx,
   input  logic                             byte_hi,
   input  logic [DATA_W-1:0]                byte_data,
   input  logic                             upd_we,
   input  logic [IDX_W-1:0]                 upd_idx,
   input  logic [ADDR_W-1:0]                upd_val,
   output logic [NUM_PTR-1:0][ADDR_W-1:0]   ptr_all
);

   for (genvar p = 0; p < NUM_PTR; p++) begin : g_ptr
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(p);
      logic [ADDR_W-1:0] q;

      always_ff @(posedge clk) begin
         if (rst) begin
            q <= '0;
         end else if (byte_we && (byte_idx == MY_IDX)) begin
            if (byte_hi) q[ADDR_W-1:DATA_W] <= byte_data[HI_W-1:0];
            else         q[DATA_W-1:0]      <= byte_data;
         end else if (upd_we && (upd_idx == MY_IDX)) begin
            q <= upd_val;
         end
      end

      assign ptr_all[p] = q;
   end

   // a byte load and a mode update never target the bank in one cycle (R11)
   assert_one_writer_R11: assert property (@(posedge clk) disable iff (rst)
      !(byte_we && upd_we));

endmodule

// File: rtl/indptr_unit.sv
module indptr_unit
   import indptr_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 12,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       NUM_PTR   = 3,
   parameter int unsigned       STRIDE_LG = 3,
   parameter logic [ADDR_W-1:0] VIRT_BASE = 'hFE0,
   parameter logic [ADDR_W-1:0] PREG_BASE = 'hFD8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wreg,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              zero_hint
);

   localparam int unsigned       IDX_W     = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
   localparam int unsigned       HI_W      = ADDR_W - DATA_W;
   localparam int unsigned       VWIN_SIZE = NUM_PTR << STRIDE_LG;
   localparam int unsigned       PWIN_SIZE = 2 * NUM_PTR;
   localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

   // elaboration-time parameter checks
   if (ADDR_W <= DATA_W || ADDR_W > 2 * DATA_W) begin : g_bad_width
      $error("indptr_unit: ADDR_W must lie in (DATA_W, 2*DATA_W]");
   end
   if (STRIDE_LG < 3) begin : g_bad_stride
      $error("indptr_unit: a virtual window needs at least 8 slots");
   end
   if (STRIDE_LG + IDX_W > ADDR_W) begin : g_bad_idx
      $error("indptr_unit: pointer index does not fit the address");
   end
   if (int'(VIRT_BASE) + VWIN_SIZE > (1 << ADDR_W) ||
       int'(PREG_BASE) + PWIN_SIZE > (1 << ADDR_W)) begin : g_bad_range
      $error("indptr_unit: a window runs past the top of memory");
   end
   if (!((int'(PREG_BASE) + PWIN_SIZE <= int'(VIRT_BASE)) ||
         (int'(PREG_BASE) >= int'(VIRT_BASE) + VWIN_SIZE))) begin : g_bad_overlap
      $error("indptr_unit: pointer registers overlap virtual windows");
   end

   // ---------------- request decode ----------------
   logic             req_virt, req_preg, req_phi;
   logic [IDX_W-1:0] req_vidx, req_pidx;
   ptr_mode_e        req_mode;

   indptr_addr_class #(
      .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .STRIDE_LG(STRIDE_LG),
      .VIRT_BASE(VIRT_BASE), .PREG_BASE(PREG_BASE)
   ) u_req_class (
      .addr(req_addr), .is_virt(req_virt), .virt_idx(req_vidx), .virt_mode(req_mode),
      .is_preg(req_preg), .preg_idx(req_pidx), .preg_hi(req_phi)
   );

   // ---------------- pointer bank ----------------
   logic [NUM_PTR-1:0][ADDR_W-1:0] ptr_all;
   logic                           byte_we, upd_we;
   logic [IDX_W-1:0]               sel_pidx;
   logic                           sel_phi;
   logic [ADDR_W-1:0]              ptr_next;

   indptr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR)) u_regs (
      .clk(clk), .rst(rst),
      .byte_we(byte_we), .byte_idx(sel_pidx), .byte_hi(sel_phi), .byte_data(wr_data),
      .upd_we(upd_we), .upd_idx(req_vidx), .upd_val(ptr_next),
      .ptr_all(ptr_all)
   );

   logic [ADDR_W-1:0] ptr_cur;
   always_comb begin
      ptr_cur = '0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (req_vidx == IDX_W'(i)) ptr_cur = ptr_all[i];
      end
   end

   // ---------------- effective address ----------------
   logic [ADDR_W-1:0] ea;
   logic              modifies;

   indptr_ea_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ea (
      .ptr_cur(ptr_cur), .mode(req_mode), .offs(wreg),
      .ea(ea), .ptr_next(ptr_next), .modifies(modifies)
   );

   logic             ea_virt, ea_preg, ea_phi;
   logic [IDX_W-1:0] ea_vidx, ea_pidx;
   ptr_mode_e        ea_mode;

   indptr_addr_class #(
      .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .STRIDE_LG(STRIDE_LG),
      .VIRT_BASE(VIRT_BASE), .PREG_BASE(PREG_BASE)
   ) u_ea_class (
      .addr(ea), .is_virt(ea_virt), .virt_idx(ea_vidx), .virt_mode(ea_mode),
      .is_preg(ea_preg), .preg_idx(ea_pidx), .preg_hi(ea_phi)
   );

   logic unused_ea_fields;
   assign unused_ea_fields = ^{ea_vidx, ea_mode};

   // ---------------- routing ----------------
   logic loop_back, sel_preg;

   always_comb begin
      loop_back = req_virt && ea_virt;
      sel_preg  = req_virt ? ea_preg : req_preg;
      sel_pidx  = req_virt ? ea_pidx : req_pidx;
      sel_phi   = req_virt ? ea_phi  : req_phi;
   end

   // pointer byte read path; the high byte is zero padded when narrower
   logic [ADDR_W-1:0] preg_word;
   logic [DATA_W-1:0] preg_byte;

   always_comb begin
      preg_word = '0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (sel_pidx == IDX_W'(i)) preg_word = ptr_all[i];
      end
   end

   if (HI_W < DATA_W) begin : g_hi_pad
      assign preg_byte = sel_phi ? {{(DATA_W-HI_W){1'b0}}, preg_word[ADDR_W-1:DATA_W]}
                                 : preg_word[DATA_W-1:0];
   end else begin : g_hi_full
      assign preg_byte = sel_phi ? preg_word[ADDR_W-1:DATA_W] : preg_word[DATA_W-1:0];
   end

   always_comb begin
      mem_addr  = req_virt ? ea : req_addr;
      mem_rd    = rd_en && !loop_back && !sel_preg;
      mem_wr    = wr_en && !loop_back && !sel_preg;
      mem_wdata = wr_data;
      if (loop_back)     rd_data = '0;
      else if (sel_preg) rd_data = preg_byte;
      else               rd_data = mem_rdata;
      zero_hint = rd_en && loop_back;
      byte_we   = wr_en && sel_preg;
      upd_we    = req_virt && modifies &&
                  (rd_en || (wr_en && !ea_virt && !ea_preg));
   end

   // ---------------- assertions ----------------
   // input rule: at most one strobe per cycle (R12)
   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (rst)
      !(rd_en && wr_en));

   assert_plain_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (rd_en || wr_en) && req_virt && req_mode == MODE_PLAIN && !(wr_en && ea_preg)
      |=> ptr_all == $past(ptr_all));

   assert_postdec_step_R4: assert property (@(posedge clk) disable iff (rst)
      rd_en && req_virt && req_mode == MODE_POSTDEC
      |=> ptr_all[$past(req_vidx)] == $past(ptr_cur) - ONE);

   assert_postinc_step_R5: assert property (@(posedge clk) disable iff (rst)
      rd_en && req_virt && req_mode == MODE_POSTINC
      |=> ptr_all[$past(req_vidx)] == $past(ptr_cur) + ONE);

   assert_preinc_addr_R6: assert property (@(posedge clk) disable iff (rst)
      mem_rd && req_virt && req_mode == MODE_PREINC |-> mem_addr == ptr_cur + ONE);

   assert_index_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (rd_en || wr_en) && req_virt && req_mode == MODE_INDEX && !(wr_en && ea_preg)
      |=> ptr_all == $past(ptr_all));

   assert_loop_write_R10: assert property (@(posedge clk) disable iff (rst)
      wr_en && req_virt && ea_virt |=> ptr_all == $past(ptr_all));

endmodule

// File: tb/indptr_unit_test.sv
module indptr_unit_test;

   localparam logic [11:0] PL = 12'hFD8;
   localparam logic [11:0] VB = 12'hFE0;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] req_addr = '0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]  wr_data = '0, wreg = '0;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr, zero_hint;
   logic [7:0]  mem_wdata, mem_rdata, rd_data;

   always #4 clk = ~clk;

   function automatic logic [7:0] memf(logic [11:0] a);
      return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'hA5;
   endfunction

   assign mem_rdata = memf(mem_addr);

   indptr_unit uut (
      .clk(clk), .rst(rst), .req_addr(req_addr), .rd_en(rd_en), .wr_en(wr_en),
      .wr_data(wr_data), .wreg(wreg), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rd_data(rd_data), .zero_hint(zero_hint)
   );

   typedef struct {
      bit          rd;
      bit          wr;
      logic [11:0] addr;
      logic [7:0]  wdata;
      bit          chk_rd;
      logic [7:0]  rdata;
      bit          zh;
      string       tag;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;

   task automatic check(bit ok, string tag, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // monitor: samples 3 ns after the falling edge, before the next rising edge
   always @(negedge clk) begin
      #3;
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(mem_rd == e.rd, e.tag, "mem_rd", int'(mem_rd), int'(e.rd));
         check(mem_wr == e.wr, e.tag, "mem_wr", int'(mem_wr), int'(e.wr));
         if (e.rd || e.wr)
            check(mem_addr == e.addr, e.tag, "mem_addr", int'(mem_addr), int'(e.addr));
         if (e.wr)
            check(mem_wdata == e.wdata, e.tag, "mem_wdata", int'(mem_wdata), int'(e.wdata));
         if (e.chk_rd)
            check(rd_data == e.rdata, e.tag, "rd_data", int'(rd_data), int'(e.rdata));
         check(zero_hint == e.zh, e.tag, "zero_hint", int'(zero_hint), int'(e.zh));
      end
   end

   function automatic exp_t mk(bit rd, bit wr, logic [11:0] a, logic [7:0] wd,
                               bit chk, logic [7:0] rdv, bit zh, string tag);
      exp_t e;
      e.rd = rd; e.wr = wr; e.addr = a; e.wdata = wd;
      e.chk_rd = chk; e.rdata = rdv; e.zh = zh; e.tag = tag;
      return e;
   endfunction

   // driver: one access per cycle, expected item queued with the stimulus
   task automatic op(logic [11:0] a, bit rd, bit wr, logic [7:0] wd,
                     logic [7:0] wr_reg, exp_t e);
      @(negedge clk);
      req_addr = a; rd_en = rd; wr_en = wr; wr_data = wd; wreg = wr_reg;
      q.push_back(e);
      @(posedge clk);
      #1;
      rd_en = 1'b0; wr_en = 1'b0;
   endtask

   task automatic dwrite(logic [11:0] a, logic [7:0] d, string tag);
      op(a, 0, 1, d, 8'h00, mk(0, 0, 12'h0, d, 0, 8'h00, 0, tag));
   endtask

   task automatic set_ptr(int n, logic [11:0] v);
      dwrite(PL + 12'(2*n), v[7:0], "R2");
      dwrite(PL + 12'(2*n+1), {4'h0, v[11:8]}, "R2");
   endtask

   task automatic chk_ptr(int n, logic [11:0] v, string tag);
      op(PL + 12'(2*n), 1, 0, 8'h00, 8'h00, mk(0, 0, 12'h0, 8'h00, 1, v[7:0], 0, tag));
      op(PL + 12'(2*n+1), 1, 0, 8'h00, 8'h00,
         mk(0, 0, 12'h0, 8'h00, 1, {4'h0, v[11:8]}, 0, tag));
   endtask

   task automatic mrd(logic [11:0] a, logic [7:0] wr_reg, logic [11:0] ea, string tag);
      op(a, 1, 0, 8'h00, wr_reg, mk(1, 0, ea, 8'h00, 1, memf(ea), 0, tag));
   endtask

   task automatic mwr(logic [11:0] a, logic [7:0] wr_reg, logic [7:0] d,
                      logic [11:0] ea, string tag);
      op(a, 0, 1, d, wr_reg, mk(0, 1, ea, d, 0, 8'h00, 0, tag));
   endtask

   bit done = 0;

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1: reset state
      chk_ptr(0, 12'h000, "R1");
      chk_ptr(1, 12'h000, "R1");
      chk_ptr(2, 12'h000, "R1");

      // R2: direct byte loads, high byte masked to four bits
      dwrite(PL + 12'd3, 8'hA7, "R2");
      dwrite(PL + 12'd2, 8'h3C, "R2");
      chk_ptr(1, 12'h73C, "R2");

      // R3: plain slot
      set_ptr(0, 12'h123);
      mrd(VB + 12'd0, 8'h00, 12'h123, "R3");
      mwr(VB + 12'd0, 8'h00, 8'h99, 12'h123, "R3");
      chk_ptr(0, 12'h123, "R3");

      // R4 with a borrow into the high byte (R8)
      set_ptr(1, 12'h200);
      mrd(VB + 12'd9, 8'h00, 12'h200, "R4");
      chk_ptr(1, 12'h1FF, "R4_R8");

      // R5 with a carry into the high byte (R8)
      set_ptr(2, 12'h0FF);
      mwr(VB + 12'd18, 8'h00, 8'h11, 12'h0FF, "R5");
      chk_ptr(2, 12'h100, "R5_R8");

      // R6: pre-increment uses the new value
      set_ptr(0, 12'h3FE);
      mrd(VB + 12'd3, 8'h00, 12'h3FF, "R6");
      mrd(VB + 12'd3, 8'h00, 12'h400, "R6");
      chk_ptr(0, 12'h400, "R6");

      // R7: indexed with signed offsets, pointer kept
      set_ptr(1, 12'h100);
      mrd(VB + 12'd12, 8'h80, 12'h080, "R7");
      mrd(VB + 12'd12, 8'h7F, 12'h17F, "R7");
      mwr(VB + 12'd12, 8'hFF, 8'h42, 12'h0FF, "R7");
      chk_ptr(1, 12'h100, "R7");
      set_ptr(1, 12'hFF0);
      mrd(VB + 12'd12, 8'h20, 12'h010, "R7_R8");

      // R8: wrap at the ends of the 12-bit space
      set_ptr(2, 12'hFFF);
      mrd(VB + 12'd18, 8'h00, 12'hFFF, "R8");
      chk_ptr(2, 12'h000, "R8");
      mrd(VB + 12'd17, 8'h00, 12'h000, "R8");
      chk_ptr(2, 12'hFFF, "R8");

      // R9: loop-back read returns zero, pointer still steps
      set_ptr(1, 12'h555);
      set_ptr(0, 12'hFE9);
      op(VB + 12'd2, 1, 0, 8'h00, 8'h00, mk(0, 0, 12'h0, 8'h00, 1, 8'h00, 1, "R9"));
      chk_ptr(0, 12'hFEA, "R9");
      chk_ptr(1, 12'h555, "R9");

      // R10: loop-back write is a full no-op
      set_ptr(2, 12'hFE0);
      op(VB + 12'd17, 0, 1, 8'h77, 8'h00, mk(0, 0, 12'h0, 8'h77, 0, 8'h00, 0, "R10"));
      chk_ptr(2, 12'hFE0, "R10");
      chk_ptr(0, 12'hFEA, "R10");

      // R11: indirect access landing on pointer bytes
      set_ptr(2, 12'h300);
      set_ptr(1, 12'hFDC);
      op(VB + 12'd10, 0, 1, 8'h5A, 8'h00, mk(0, 0, 12'h0, 8'h5A, 0, 8'h00, 0, "R11"));
      chk_ptr(2, 12'h35A, "R11");
      chk_ptr(1, 12'hFDC, "R11");
      set_ptr(1, 12'hFDD);
      op(VB + 12'd10, 1, 0, 8'h00, 8'h00, mk(0, 0, 12'h0, 8'h00, 1, 8'h03, 0, "R11"));
      chk_ptr(1, 12'hFDE, "R11");
      set_ptr(0, 12'hFD9);
      op(VB + 12'd2, 0, 1, 8'hB6, 8'h00, mk(0, 0, 12'h0, 8'hB6, 0, 8'h00, 0, "R11"));
      chk_ptr(0, 12'h6D9, "R11");

      // R12: pass-through, including unused window slots
      mrd(12'h050, 8'h00, 12'h050, "R12");
      mwr(VB + 12'd5, 8'h00, 8'h13, VB + 12'd5, "R12");
      mrd(12'hFF7, 8'h00, 12'hFF7, "R12");
      chk_ptr(0, 12'h6D9, "R12");

      repeat (2) @(posedge clk);
      done = 1;
      finish_run();
   end

endmodule